// File: doc/BRIEF.md
# Converter Clock Source Selector and Prescaler

This block produces the conversion-clock enable for an analog-to-digital converter. Everything runs on the bus clock. Each source appears as a one-cycle tick in that domain, and the output is a single-cycle enable pulse, `adck_en`, rather than a gated clock. A configuration register picks one of four sources and one of four power-of-two divide ratios. The register is loaded by a write strobe. The four sources are:

- the bus clock itself;
- the bus clock halved;
- an alternate tick input;
- an internal asynchronous oscillator.

The internal oscillator is not kept running unless a keep-alive bit asks for it. When it is the selected source and the keep-alive bit is clear, the block requests the oscillator (`osc_on`) only while a conversion is requested or running. Each time the oscillator turns on, it must first be counted through a programmable number of reference ticks before it is treated as usable. A conversion request is acknowledged with a one-cycle grant only once the selected source is usable. During a low-power stop, only the internal oscillator can still clock conversions.

Top module: `adcclk_gen`

## Requirements
- R1: After reset the configuration is source 0 (bus clock), divide code 0, keep-alive 0. `adck_en` is therefore high in every cycle after the first clock edge, and `conv_grant` and `osc_on` are low.
- R2: The source code `cfg_src` selects the source: 0 is the bus clock (a tick every cycle), 1 is the bus clock halved (a tick every second cycle), 2 is `alt_tick`, and 3 is `osc_tick` gated by the oscillator being ready. With divide code 0, `adck_en` pulses once per source tick.
- R3: Divide codes 0, 1, 2 and 3 give one `adck_en` pulse per 1, 2, 4 and 8 source ticks. Source 1 with divide code 3 gives one pulse every 16 bus cycles.
- R4: A write (`cfg_wr`) that changes the source or the divide code clears the divider. No pulse can follow that clock edge, even one that was due then. With the bus source and ratio N, `adck_en` stays low for exactly N cycles after the write edge and then pulses.
- R5: With source 3 and keep-alive 0, `osc_on` rises one cycle after `conv_req` or `conv_active` is high. It falls one cycle after both are low.
- R6: With source 3, `clk_ready` goes high only after `startup_lim` reference ticks have been counted while `osc_on` is high. The count restarts from zero each time the oscillator turns on, and `osc_tick` produces no pulse while `clk_ready` is low.
- R7: With keep-alive 1, `osc_on` stays high with no conversion activity. Once it is ready, a request is granted one cycle later.
- R8: `conv_grant` is a one-cycle pulse. It is raised in the cycle after `conv_req` is sampled high together with `clk_ready`, and never without `clk_ready`.
- R9: While `stop_mode` is high, sources 0 to 2 produce no `adck_en` pulses and `clk_ready` is low. Source 3 keeps pulsing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Loads the three configuration fields |
| cfg_src | input | 2 | Source code (0 bus, 1 bus halved, 2 alternate, 3 oscillator) |
| cfg_div | input | 2 | Divide code (ratio 2^code) |
| cfg_async_keep | input | 1 | Keeps the oscillator running at all times |
| startup_lim | input | 8 | Reference ticks required before the oscillator is usable |
| stop_mode | input | 1 | Low-power stop; only the oscillator stays usable |
| alt_tick | input | 1 | Alternate source tick |
| osc_tick | input | 1 | Oscillator tick |
| ref_tick | input | 1 | Free-running reference tick for startup timing |
| conv_req | input | 1 | Conversion start request, held until granted |
| conv_active | input | 1 | A conversion sequence is running |
| adck_en | output | 1 | Divided conversion-clock enable pulse |
| clk_ready | output | 1 | The selected source is usable |
| conv_grant | output | 1 | One-cycle acknowledge of a conversion start |
| osc_on | output | 1 | Oscillator run request |

## Verification
Two events can land in the same cycle: a configuration write and the source tick that completes a divide period. To provoke this, the bench aligns on an `adck_en` pulse at ratio 4 and writes a new ratio three cycles later, exactly on the edge where the next pulse is due. The write must win. The bench checks that no pulse appears, then two low cycles for the new ratio 2, then a pulse. A second overlap is between oscillator turn-on and the startup count. There the bench replays the reference ticks that land while `osc_on` is high and compares `clk_ready` in every cycle against that tally.

// File: rtl/adcclk_pkg.sv
package adcclk_pkg;

    localparam int SRC_W    = 2;
    localparam int DIVSEL_W = 2;

    typedef enum logic [SRC_W-1:0] {
        SRC_BUS      = 2'd0,
        SRC_BUS_HALF = 2'd1,
        SRC_ALT      = 2'd2,
        SRC_ASYNC    = 2'd3
    } src_e;

    typedef struct packed {
        src_e                sel;
        logic [DIVSEL_W-1:0] div;
        logic                keep;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{sel: SRC_BUS, div: '0, keep: 1'b0};

endpackage

// File: rtl/adcclk_src_mux.sv
module adcclk_src_mux
    import adcclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  src_e sel,
    input  logic stop_mode,
    input  logic alt_tick,
    input  logic osc_tick,
    input  logic osc_rdy,
    output logic src_tick,
    output logic src_ready
);

    typedef struct packed {
        logic half;
    } mux_st_t;

    mux_st_t st_q, st_d;
    logic    raw_tick;

    always_comb begin
        st_d      = st_q;
        st_d.half = ~st_q.half;

        unique case (sel)
            SRC_BUS:      raw_tick = 1'b1;
            SRC_BUS_HALF: raw_tick = st_q.half;
            SRC_ALT:      raw_tick = alt_tick;
            default:      raw_tick = osc_tick & osc_rdy;
        endcase

        // In stop only the internal oscillator remains usable
        src_ready = (sel == SRC_ASYNC) ? osc_rdy : ~stop_mode;
        src_tick  = raw_tick & src_ready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/adcclk_async_ctl.sv
module adcclk_async_ctl #(
    parameter int STARTUP_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 keep,
    input  logic                 async_sel,
    input  logic                 conv_req,
    input  logic                 conv_active,
    input  logic                 ref_tick,
    input  logic [STARTUP_W-1:0] startup_lim,
    output logic                 osc_on,
    output logic                 osc_rdy
);

    typedef struct packed {
        logic                 on;
        logic [STARTUP_W-1:0] cnt;
    } osc_st_t;

    osc_st_t st_q, st_d;
    logic    demand;

    always_comb begin
        st_d   = st_q;
        demand = keep | (async_sel & (conv_req | conv_active));
        st_d.on = demand;
        if (!demand) begin
            st_d.cnt = '0;
        end else if (st_q.on && ref_tick && (st_q.cnt < startup_lim)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        osc_on  = st_q.on;
        osc_rdy = st_q.on & (st_q.cnt >= startup_lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/adcclk_prescaler.sv
module adcclk_prescaler #(
    parameter int DIVSEL_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                src_tick,
    input  logic [DIVSEL_W-1:0] div,
    input  logic                clr,
    output logic                en
);

    localparam int NCODES = 1 << DIVSEL_W;
    localparam int CNT_W  = (NCODES > 2) ? (NCODES - 1) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             en;
    } div_st_t;

    div_st_t          st_q, st_d;
    logic [CNT_W-1:0] term;

    always_comb begin
        term    = CNT_W'((32'd1 << div) - 32'd1);
        st_d    = st_q;
        st_d.en = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (src_tick) begin
            if (st_q.cnt >= term) begin
                st_d.cnt = '0;
                st_d.en  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        en = st_q.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/adcclk_gen.sv
module adcclk_gen
    import adcclk_pkg::*;
#(
    parameter int STARTUP_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [1:0]           cfg_src,
    input  logic [1:0]           cfg_div,
    input  logic                 cfg_async_keep,
    input  logic [STARTUP_W-1:0] startup_lim,
    input  logic                 stop_mode,
    input  logic                 alt_tick,
    input  logic                 osc_tick,
    input  logic                 ref_tick,
    input  logic                 conv_req,
    input  logic                 conv_active,
    output logic                 adck_en,
    output logic                 clk_ready,
    output logic                 conv_grant,
    output logic                 osc_on
);

    typedef struct packed {
        cfg_t cfg;
        logic grant;
    } top_st_t;

    top_st_t st_q, st_d;
    cfg_t    wdata;
    logic    cfg_change;
    logic    sel_is_async;
    logic    osc_rdy;
    logic    src_tick;

    always_comb begin
        wdata      = '{sel: src_e'(cfg_src), div: cfg_div, keep: cfg_async_keep};
        cfg_change = cfg_wr & ((wdata.sel != st_q.cfg.sel) | (wdata.div != st_q.cfg.div));
        st_d       = st_q;
        if (cfg_wr) st_d.cfg = wdata;
        // Hold the request off until the source is usable; pulse once
        st_d.grant = conv_req & clk_ready & ~st_q.grant;
        sel_is_async = (st_q.cfg.sel == SRC_ASYNC);
        conv_grant   = st_q.grant;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cfg: CFG_RESET, grant: 1'b0};
        else        st_q <= st_d;
    end

    adcclk_async_ctl #(.STARTUP_W(STARTUP_W)) u_async (
        .clk         (clk),
        .rst_n       (rst_n),
        .keep        (st_q.cfg.keep),
        .async_sel   (sel_is_async),
        .conv_req    (conv_req),
        .conv_active (conv_active),
        .ref_tick    (ref_tick),
        .startup_lim (startup_lim),
        .osc_on      (osc_on),
        .osc_rdy     (osc_rdy)
    );

    adcclk_src_mux u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (st_q.cfg.sel),
        .stop_mode (stop_mode),
        .alt_tick  (alt_tick),
        .osc_tick  (osc_tick),
        .osc_rdy   (osc_rdy),
        .src_tick  (src_tick),
        .src_ready (clk_ready)
    );

    adcclk_prescaler #(.DIVSEL_W(DIVSEL_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .div      (st_q.cfg.div),
        .clr      (cfg_change),
        .en       (adck_en)
    );

endmodule

// File: rtl/adcclk_gen_chk.sv
module adcclk_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic stop_mode,
    input logic sel_is_async,
    input logic cfg_change,
    input logic adck_en,
    input logic clk_ready,
    input logic conv_grant,
    input logic osc_on
);

    // R8
    grant_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_grant |-> $past(clk_ready));

    // R8
    grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_grant |=> !conv_grant);

    // R9
    stop_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stop_mode) && !$past(sel_is_async)) |-> !adck_en);

    // R4
    cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_change) |-> !adck_en);

    // R6
    async_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_is_async && !osc_on) |-> !clk_ready);

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!conv_grant && !osc_on);
        end
    end

endmodule

bind adcclk_gen adcclk_gen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .stop_mode    (stop_mode),
    .sel_is_async (sel_is_async),
    .cfg_change   (cfg_change),
    .adck_en      (adck_en),
    .clk_ready    (clk_ready),
    .conv_grant   (conv_grant),
    .osc_on       (osc_on)
);

// File: tb/adcclk_gen_bench.sv
module adcclk_gen_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_src = 2'd0;
    logic [1:0] cfg_div = 2'd0;
    logic       cfg_async_keep = 1'b0;
    logic [7:0] startup_lim = 8'd3;
    logic       stop_mode = 1'b0;
    logic       alt_tick = 1'b0;
    logic       osc_tick = 1'b0;
    logic       ref_tick = 1'b0;
    logic       conv_req = 1'b0;
    logic       conv_active = 1'b0;
    logic       adck_en, clk_ready, conv_grant, osc_on;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    adcclk_gen u_adcclk_gen (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_src(cfg_src),
        .cfg_div(cfg_div), .cfg_async_keep(cfg_async_keep),
        .startup_lim(startup_lim), .stop_mode(stop_mode),
        .alt_tick(alt_tick), .osc_tick(osc_tick), .ref_tick(ref_tick),
        .conv_req(conv_req), .conv_active(conv_active),
        .adck_en(adck_en), .clk_ready(clk_ready),
        .conv_grant(conv_grant), .osc_on(osc_on)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Tick sources change just after the rising edge: alt every 5, osc every 3, ref every 4
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            alt_tick = (cyc % 5) == 0;
            osc_tick = (cyc % 3) == 0;
            ref_tick = (cyc % 4) == 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [1:0] d, input logic k);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_src = s; cfg_div = d; cfg_async_keep = k;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Measure cycles between two successive adck_en pulses
    task automatic measure(input int exp, input string tag);
        int k = 0;
        int guard = 0;
        do begin @(negedge clk); guard++; end while (!adck_en && guard < 100);
        do begin @(negedge clk); k++; end while (!adck_en && k < 100);
        chk(k == exp, tag, k, exp);
    endtask

    task automatic t_reset();
        chk(adck_en == 1'b0 && conv_grant == 1'b0 && osc_on == 1'b0, "R1 in reset", adck_en, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        begin
            int ones = 0;
            for (int i = 0; i < 5; i++) begin @(negedge clk); ones += int'(adck_en); end
            chk(ones == 5, "R1 default bus div1", ones, 5);
        end
        chk(conv_grant == 1'b0 && osc_on == 1'b0, "R1 idle outputs", osc_on, 0);
    endtask

    task automatic t_rates();
        cfg_write(2'd0, 2'd1, 1'b0); measure(2, "R3 bus div2");
        cfg_write(2'd0, 2'd2, 1'b0); measure(4, "R3 bus div4");
        cfg_write(2'd0, 2'd3, 1'b0); measure(8, "R3 bus div8");
        cfg_write(2'd1, 2'd0, 1'b0); measure(2, "R2 bus half");
        cfg_write(2'd1, 2'd3, 1'b0); measure(16, "R3 half div8 total 16");
        cfg_write(2'd2, 2'd0, 1'b0); measure(5, "R2 alt div1");
        cfg_write(2'd2, 2'd1, 1'b0); measure(10, "R3 alt div2");
    endtask

    task automatic t_clear();
        int lows = 0;
        cfg_write(2'd0, 2'd0, 1'b0);
        @(negedge clk);
        // Write ratio 4; cfg_write returns at the sample after the write edge
        @(negedge clk);
        cfg_wr = 1'b1; cfg_src = 2'd0; cfg_div = 2'd2;
        @(negedge clk);
        cfg_wr = 1'b0;
        lows = 0;
        while (!adck_en && lows < 20) begin lows++; @(negedge clk); end
        chk(lows == 4, "R4 low cycles after write", lows, 4);
        // Write lands on the edge where a ratio-4 pulse is due
        repeat (3) @(negedge clk);
        cfg_wr = 1'b1; cfg_div = 2'd1;
        @(negedge clk);
        cfg_wr = 1'b0;
        chk(adck_en == 1'b0, "R4 due pulse suppressed", adck_en, 0);
        @(negedge clk);
        chk(adck_en == 1'b0, "R4 second low", adck_en, 0);
        @(negedge clk);
        chk(adck_en == 1'b1, "R4 first pulse new ratio", adck_en, 1);
    endtask

    task automatic t_grant_bus();
        cfg_write(2'd0, 2'd0, 1'b0);
        @(negedge clk); conv_req = 1'b1;
        @(negedge clk);
        chk(conv_grant == 1'b1, "R8 grant one cycle after request", conv_grant, 1);
        conv_req = 1'b0;
        @(negedge clk);
        chk(conv_grant == 1'b0, "R8 grant single cycle", conv_grant, 0);
        stop_mode = 1'b1; conv_req = 1'b1;
        begin
            int g = 0;
            for (int i = 0; i < 6; i++) begin @(negedge clk); g += int'(conv_grant); end
            chk(g == 0, "R8 no grant without ready", g, 0);
        end
        conv_req = 1'b0; stop_mode = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_async_demand();
        int landed = 0;
        int bad = 0;
        bit prev_rdy = 1'b0;
        bit got = 1'b0;
        startup_lim = 8'd3;
        cfg_write(2'd3, 2'd0, 1'b0);
        repeat (4) @(negedge clk);
        chk(osc_on == 1'b0 && clk_ready == 1'b0 && adck_en == 1'b0, "R5 idle oscillator off", osc_on, 0);
        conv_req = 1'b1;
        @(negedge clk);
        chk(osc_on == 1'b1, "R5 on one cycle after request", osc_on, 1);
        for (int i = 0; i < 80 && !got; i++) begin
            if (conv_grant) begin
                got = 1'b1;
                chk(prev_rdy == 1'b1, "R8 async grant after ready", prev_rdy, 1);
                conv_req = 1'b0; conv_active = 1'b1;
            end else begin
                if (clk_ready != (osc_on && landed >= 3)) bad++;
                if (!clk_ready && adck_en) bad++;
                prev_rdy = clk_ready;
                if (osc_on && ref_tick && landed < 3) landed++;
                @(negedge clk);
            end
        end
        chk(got, "R6 request eventually granted", got, 1);
        chk(bad == 0, "R6 ready follows startup count", bad, 0);
        repeat (5) @(negedge clk);
        conv_active = 1'b0;
        @(negedge clk);
        chk(osc_on == 1'b0 && clk_ready == 1'b0, "R5 off after conversions end", osc_on, 0);
        // Restart: startup counted again from zero
        conv_req = 1'b1;
        @(negedge clk);
        chk(osc_on == 1'b1 && clk_ready == 1'b0, "R6 restart not ready at once", clk_ready, 0);
        @(negedge clk);
        chk(clk_ready == 1'b0, "R6 restart still counting", clk_ready, 0);
        conv_req = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_keep();
        int w = 0;
        cfg_write(2'd3, 2'd0, 1'b1);
        while (!clk_ready && w < 60) begin @(negedge clk); w++; end
        chk(clk_ready == 1'b1, "R7 ready with keep-alive", clk_ready, 1);
        begin
            int offs = 0;
            for (int i = 0; i < 10; i++) begin @(negedge clk); offs += int'(!osc_on || !clk_ready); end
            chk(offs == 0, "R7 stays on without conversions", offs, 0);
        end
        conv_req = 1'b1;
        @(negedge clk);
        chk(conv_grant == 1'b1, "R7 immediate grant", conv_grant, 1);
        conv_req = 1'b0;
        measure(3, "R2 oscillator source div1");
    endtask

    task automatic t_stop();
        int ones = 0;
        int rdy = 0;
        cfg_write(2'd0, 2'd0, 1'b0);
        repeat (2) @(negedge clk);
        stop_mode = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            ones += int'(adck_en);
            rdy += int'(clk_ready);
        end
        chk(ones == 0, "R9 bus source silent in stop", ones, 0);
        chk(rdy == 0, "R9 not ready in stop", rdy, 0);
        stop_mode = 1'b0;
        cfg_write(2'd3, 2'd0, 1'b1);
        repeat (20) @(negedge clk);
        stop_mode = 1'b1;
        measure(3, "R9 oscillator runs in stop");
        stop_mode = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_rates();
        t_clear();
        t_grant_bus();
        t_async_demand();
        t_keep();
        t_stop();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule